// File: doc/BRIEF.md
# Clear-on-read RTC interrupt controller

This block gathers three event strobes from a real-time clock subsystem (watchdog expiry, alarm match and supply-failure detection) and merges them into one interrupt pin. Each strobe latches a sticky flag. A configuration register chooses which flags may drive the pin, whether the pin gives a fixed-length pulse or holds a level, and whether the pin is active high or active low.

A host reads the flags or the configuration through a small register port. Any read clears every flag. In level mode the read drops the pin. In pulse mode the read also ends a pulse that is still running. The configuration register comes up with a default that enables only the supply-failure interrupt, as an active-low pulse. The timekeeping counters, the comparator, the watchdog counter, the analog monitor and the pad driver are outside the block, and it sees them only as single-cycle strobes and a pin level.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the flags read 0x00, the configuration reads 0x24 and irq_out is high (inactive, because active-low is selected).
- R2: A strobe sets its flag at the next clock edge. A flags read (host_sel=0) returns watchdog in bit 7, alarm in bit 6 and supply-fail in bit 5, with zeros elsewhere. Read data appears on host_rdata one cycle after host_rd_en.
- R3: A read of either register (host_sel=0 or 1) clears all flags at the same edge that captures the read data.
- R4: A flag whose enable bit is 0 never makes irq_out active.
- R5: In level mode (config bit 2 = 0), irq_out is active while any enabled flag is set and inactive from the cycle after a clearing read.
- R6: In pulse mode (config bit 2 = 1), an enabled flag that is newly set makes irq_out active for exactly PULSE_CYCLES cycles, starting the cycle after the strobe.
- R7: A read during a pulse makes irq_out inactive from the next cycle.
- R8: An enabled strobe that arrives while a pulse is running does not lengthen that pulse.
- R9: Config bit 1 selects polarity (1 = active high, 0 = active low). The inactive level is the inverse of the active level.
- R10: When a strobe coincides with a clearing read, the read returns the old flags and the new flag stays set for the next read.
- R11: Config bits 7, 6 and 5 enable watchdog, alarm and supply-fail. Only bits 7, 6, 5, 2 and 1 are writable, and the other bits read 0. A write with host_sel=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| pfail_evt | input | 1 | Supply-failure strobe |
| host_sel | input | 1 | Register select: 0 flags, 1 configuration |
| host_rd_en | input | 1 | Read strobe, which clears all flags |
| host_wr_en | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt pin level |

## Verification
A flag that is stuck or lost shows up on the very next flags read, and also shows up on irq_out one cycle after the strobe when that source is enabled. A pulse counter that is loaded with the wrong value, reloaded by a second strobe, or not cleared by a read changes the number of cycles irq_out stays active. The bench counts that number exactly for every combination of enable mask, mode, polarity and strobe pattern. A clear and a latch that are ordered wrongly, with a strobe in the same cycle as a read, lose the event on the following read.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int PULSE_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdog_evt,
  input  logic       alarm_evt,
  input  logic       pfail_evt,
  input  logic       host_sel,
  input  logic       host_rd_en,
  input  logic       host_wr_en,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq_out
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [7:0] CFG_RESET = 8'h24;
  localparam logic [7:0] CFG_MASK  = 8'hE6;

  logic [2:0]    flags;
  logic [7:0]    cfg;
  logic [CW-1:0] cnt;

  wire [2:0] evts       = {wdog_evt, alarm_evt, pfail_evt};
  wire [2:0] en         = cfg[7:5];
  wire       pulse_mode = cfg[2];
  wire       pol_high   = cfg[1];
  wire [2:0] kept       = host_rd_en ? 3'b000 : flags;
  wire [2:0] new_set    = evts & en & ~kept;
  wire       level_act  = |(flags & en);
  wire       pulse_act  = (cnt != '0);
  wire       act        = pulse_mode ? pulse_act : level_act;

  assign irq_out = pol_high ? act : ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      cfg        <= CFG_RESET;
      cnt        <= '0;
      host_rdata <= '0;
    end else begin
      flags <= kept | evts;
      if (host_wr_en && host_sel)
        cfg <= host_wdata & CFG_MASK;
      if (host_rd_en)
        host_rdata <= host_sel ? cfg : {flags, 5'b0};
      if (pulse_mode && (|new_set) && (!pulse_act || host_rd_en))
        cnt <= CW'(PULSE_CYCLES);
      else if (host_rd_en)
        cnt <= '0;
      else if (pulse_act)
        cnt <= cnt - 1'b1;
    end
  end

  // R3
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && evts == 3'b000) |=> (flags == 3'b000));

  // R10
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evts != 3'b000) |=> ((flags & $past(evts)) == $past(evts)));

  // R8
  no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_act && !host_rd_en) |=> (cnt < $past(cnt)));

  // R7
  pulse_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && new_set == 3'b000) |=> !pulse_act);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_en && host_sel) |=> $stable(cfg));

  // R11
  cfg_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg & ~CFG_MASK) == 8'h00);
endmodule

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;
  localparam int P = 6;
  logic clk = 0, rst_n = 0;
  logic wdog_evt = 0, alarm_evt = 0, pfail_evt = 0;
  logic host_sel = 0, host_rd_en = 0, host_wr_en = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq_out;
  int checks = 0, failures = 0;

  rtc_irq_ctrl #(.PULSE_CYCLES(P)) i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wdog_evt(wdog_evt), .alarm_evt(alarm_evt),
    .pfail_evt(pfail_evt), .host_sel(host_sel), .host_rd_en(host_rd_en),
    .host_wr_en(host_wr_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_out(irq_out));

  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel);
    host_sel = sel; host_rd_en = 1; tick(); host_rd_en = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    host_sel = sel; host_wr_en = 1; host_wdata = d; tick(); host_wr_en = 0;
  endtask

  task automatic evt(input logic [2:0] e);
    {wdog_evt, alarm_evt, pfail_evt} = e; tick(); {wdog_evt, alarm_evt, pfail_evt} = 3'b000;
  endtask

  function automatic logic pin(input logic pol, input logic a);
    return pol ? a : ~a;
  endfunction

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 irq idle", irq_out, 1);
    rst_n = 1; tick();
    chk("R1 irq idle after release", irq_out, 1);
    rd(1); chk("R1 cfg default", host_rdata, 8'h24);
    rd(0); chk("R1 flags zero", host_rdata, 8'h00);

    // R6 default config: supply-fail pulse active low
    evt(3'b001);
    chk("R6 default pulse start", irq_out, 0);
    for (int i = 1; i < P; i++) tick();
    chk("R6 default pulse last", irq_out, 0);
    tick(); chk("R6 default pulse end", irq_out, 1);
    rd(0); chk("R2 pfail bit", host_rdata, 8'h20);

    // R11 reserved bits and flags-address write ignored
    wr(1, 8'hFF); rd(1); chk("R11 writable mask", host_rdata, 8'hE6);
    wr(0, 8'h00); rd(1); chk("R11 flags write ignored", host_rdata, 8'hE6);

    // R2 R4 R5 R6 R9 sweep
    for (int en = 0; en < 8; en++)
      for (int m = 0; m < 2; m++)
        for (int pol = 0; pol < 2; pol++)
          for (int e = 1; e < 8; e++) begin
            logic [7:0] c;
            logic a;
            c = {en[2:0], 2'b00, m[0], pol[0], 1'b0};
            wr(1, c); rd(1);
            chk("R11 cfg readback", host_rdata, c);
            chk("R9 idle level", irq_out, pin(pol[0], 1'b0));
            a = |(e[2:0] & en[2:0]);
            evt(e[2:0]);
            chk("R4 R9 start", irq_out, pin(pol[0], a));
            for (int i = 1; i < P; i++) tick();
            chk("R6 R5 held", irq_out, pin(pol[0], a));
            tick();
            chk("R6 R5 after window", irq_out, pin(pol[0], m ? 1'b0 : a));
            rd(0);
            chk("R2 flag layout", host_rdata, {e[2:0], 5'b0});
            chk("R5 R3 cleared", irq_out, pin(pol[0], 1'b0));
            rd(0);
            chk("R3 flags empty", host_rdata, 8'h00);
          end

    // R7 read cuts pulse (active high, all enabled, pulse)
    wr(1, 8'hE6); rd(1);
    evt(3'b010); tick();
    chk("R7 pulse running", irq_out, 1);
    rd(1); chk("R7 cut by cfg read", irq_out, 0);
    chk("R3 cfg read data", host_rdata, 8'hE6);
    rd(0); chk("R3 cleared by cfg read", host_rdata, 8'h00);

    // R8 no extension
    evt(3'b001); tick();
    evt(3'b100);
    for (int i = 3; i < P; i++) tick();
    chk("R8 still in pulse", irq_out, 1);
    tick(); chk("R8 not extended", irq_out, 0);
    rd(0); chk("R8 both flags", host_rdata, 8'hA0);

    // R10 event with read in same cycle (level mode)
    wr(1, 8'hE2); rd(1);
    evt(3'b010);
    {wdog_evt, alarm_evt, pfail_evt} = 3'b100; rd(0);
    {wdog_evt, alarm_evt, pfail_evt} = 3'b000;
    chk("R10 old flags", host_rdata, 8'h40);
    chk("R10 level still active", irq_out, 1);
    rd(0); chk("R10 new flag kept", host_rdata, 8'h80);
    chk("R5 level released", irq_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule